// File: doc/BRIEF.md
# Serial NOR Flash Range Erase Sequencer

This block erases a contiguous range of a serial NOR flash through a byte-handshake SPI master. A requester supplies a start address, a byte length and a granule select, which picks either 4 KiB or large-sector erase, and pulses a start strobe. The block first checks the range against the device size and the granule alignment. A bad range is rejected without any bus traffic.

For an accepted range, the block works through one granule at a time. It polls the device status until the write-in-progress flag reads clear, then sends a write-enable frame, then sends the erase frame, which carries the 24-bit address. Each of these commands uses its own chip-select assertion. If a granule stays busy for too many status reads, the whole request stops with a timeout code. The outcome is reported as a one-cycle done pulse that carries a result code.

The SPI shifter sits outside the block. The block holds a byte request with its transmit byte until the shifter acknowledges it, and takes the received byte in the acknowledge cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset and whenever no request is in progress, `busy`, `spiCs`, `spiReq` and `donePulse` are all low.
- R2: A request is rejected with result code 1 and with no chip-select activity in these cases: start plus length exceeds 2^DEV_LOG2 bytes, or the start or the length is not a multiple of the selected granule size.
- R3: Before each erase, the block issues status frames until a status byte has bit 0 (write in progress) clear. Each status frame is two bytes: 0x05 followed by one dummy byte, and the status is the byte received for the second one.
- R4: After the status poll finds the device idle, the block sends a frame that contains only the byte 0x06.
- R5: The erase frame is four bytes: the opcode, then address bits 23:16, then bits 15:8, then bits 7:0.
- R6: The erase opcode is 0x20 when `granSel` is 0 (4 KiB granule) and 0xD8 when `granSel` is 1 (2^LARGE_LOG2-byte granule, 64 KiB by default).
- R7: The erase address starts at the start address and advances by one granule per erase frame. Exactly length/granule erase frames are sent.
- R8: If POLL_LIMIT status reads in a row report busy for one granule, the request ends with result code 2. No further frames follow, and later granules are not erased. A device that clears on read POLL_LIMIT is still accepted.
- R9: Every request ends with exactly one `donePulse` that lasts one cycle. `doneCode` is 0 on success and never 3.
- R10: `spiReq` is only high while `spiCs` is high. Once raised, `spiReq` and `spiTxData` hold steady until the cycle in which `spiAck` is seen.
- R11: `startReq` is ignored while `busy` is high. The running request's frames and its single done pulse are unaffected.
- R12: A zero-length request that is aligned and in range completes with code 0 and no chip-select activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe, taken only when idle |
| startAddr | input | 24 | First byte address of the range |
| eraseLen | input | 25 | Range length in bytes |
| granSel | input | 1 | 0: 4 KiB granule, 1: large-sector granule |
| busy | output | 1 | A request is in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| doneCode | output | 2 | 0 ok, 1 range/alignment error, 2 timeout |
| spiCs | output | 1 | Chip select, high while a frame is active |
| spiReq | output | 1 | Byte transfer request to the shifter |
| spiTxData | output | 8 | Byte to transmit |
| spiAck | input | 1 | Shifter has finished the current byte |
| spiRxData | input | 8 | Byte received, valid with spiAck |

## Verification
The hardest situations to reach from the ports are the edges of the busy poll: a granule that clears on exactly the last permitted status read, one that never clears, and a timeout that hits a later granule after earlier ones were already erased. The bench's flash model has a programmable busy count. It loads one value for the first granule and reloads a second value after every erase frame, and it answers each status read from that count. This lets each edge case be set up directly. Acknowledge latency is also varied, so that the request-hold rule is exercised across several wait lengths.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam int FES_ADDR_BYTES = 3;
  localparam int FES_ADDR_W     = 8 * FES_ADDR_BYTES;
  localparam int FES_LEN_W      = FES_ADDR_W + 1;

  localparam logic [7:0] OP_STATUS      = 8'h05;
  localparam logic [7:0] OP_WREN        = 8'h06;
  localparam logic [7:0] OP_ERASE_SMALL = 8'h20;
  localparam logic [7:0] OP_ERASE_LARGE = 8'hD8;
  localparam logic [7:0] BYTE_DUMMY     = 8'h00;

  typedef enum logic [1:0] {
    DONE_OK      = 2'd0,
    DONE_RANGE   = 2'd1,
    DONE_TIMEOUT = 2'd2
  } doneCode_e;

  typedef enum logic [2:0] {
    TX_STATUS,
    TX_DUMMY,
    TX_WREN,
    TX_OPCODE,
    TX_ADDR_HI,
    TX_ADDR_MID,
    TX_ADDR_LO
  } txSel_e;

  typedef struct packed {
    logic   load;
    logic   pollClr;
    logic   pollInc;
    logic   srLoad;
    logic   advance;
    txSel_e txSel;
  } ctlStrobe_t;

endpackage

// File: rtl/fes_dpath.sv
module fes_dpath
  import fes_pkg::*;
#(
  parameter int DEV_LOG2   = 20,
  parameter int SMALL_LOG2 = 12,
  parameter int LARGE_LOG2 = 16,
  parameter int POLL_LIMIT = 100000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [FES_ADDR_W-1:0] startAddr,
  input  logic [FES_LEN_W-1:0]  eraseLen,
  input  logic                  granSel,
  input  logic [7:0]            spiRxData,
  output logic                  rangeBad,
  output logic                  remZero,
  output logic                  srWip,
  output logic                  pollAtLimit,
  output logic [7:0]            txByte
);

  localparam int SUM_W  = FES_LEN_W + 1;
  localparam int PCNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [SUM_W-1:0]     DEV_SIZE = SUM_W'(1) << DEV_LOG2;
  localparam logic [FES_LEN_W-1:0] SMALL_SZ = FES_LEN_W'(1) << SMALL_LOG2;
  localparam logic [FES_LEN_W-1:0] LARGE_SZ = FES_LEN_W'(1) << LARGE_LOG2;
  localparam logic [PCNT_W-1:0]    POLL_LAST = PCNT_W'(POLL_LIMIT - 1);

  logic [FES_ADDR_W-1:0] curAddr;
  logic [FES_LEN_W-1:0]  remLen;
  logic                  granLarge;
  logic                  srWipQ;
  logic [PCNT_W-1:0]     pollCnt;
  logic [FES_LEN_W-1:0]  granSz;
  logic [FES_LEN_W-1:0]  granMask;
  logic [SUM_W-1:0]      endAddr;
  logic [7:0]            addrLane [FES_ADDR_BYTES];
  logic                  rxUnused;

  assign granSz   = granLarge ? LARGE_SZ : SMALL_SZ;
  assign granMask = granSz - FES_LEN_W'(1);

  // Working registers: start, remaining length, granule choice
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remLen    <= '0;
      granLarge <= 1'b0;
    end else if (strobe.load) begin
      curAddr   <= startAddr;
      remLen    <= eraseLen;
      granLarge <= granSel;
    end else if (strobe.advance) begin
      curAddr <= curAddr + granSz[FES_ADDR_W-1:0];
      remLen  <= remLen - granSz;
    end
  end

  // Range and alignment test on the captured request
  assign endAddr  = SUM_W'(curAddr) + SUM_W'(remLen);
  assign rangeBad = (endAddr > DEV_SIZE)
                 || (|(FES_LEN_W'(curAddr) & granMask))
                 || (|(remLen & granMask));
  assign remZero  = (remLen == '0);

  // Status capture: only the busy flag steers the sequence
  always_ff @(posedge clk) begin
    if (!rstN)              srWipQ <= 1'b0;
    else if (strobe.srLoad) srWipQ <= spiRxData[0];
  end
  assign srWip    = srWipQ;
  assign rxUnused = ^spiRxData[7:1];

  // Busy-poll retry counter
  always_ff @(posedge clk) begin
    if (!rstN)               pollCnt <= '0;
    else if (strobe.pollClr) pollCnt <= '0;
    else if (strobe.pollInc) pollCnt <= pollCnt + PCNT_W'(1);
  end
  assign pollAtLimit = (pollCnt == POLL_LAST);

  // Address byte lanes, lane 0 is the least significant
  for (genvar k = 0; k < FES_ADDR_BYTES; k++) begin : g_lane
    assign addrLane[k] = curAddr[8*k +: 8];
  end

  always_comb begin
    case (strobe.txSel)
      TX_STATUS:   txByte = OP_STATUS;
      TX_DUMMY:    txByte = BYTE_DUMMY;
      TX_WREN:     txByte = OP_WREN;
      TX_OPCODE:   txByte = granLarge ? OP_ERASE_LARGE : OP_ERASE_SMALL;
      TX_ADDR_HI:  txByte = addrLane[2];
      TX_ADDR_MID: txByte = addrLane[1];
      TX_ADDR_LO:  txByte = addrLane[0];
      default:     txByte = BYTE_DUMMY;
    endcase
  end

endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       spiAck,
  input  logic       rangeBad,
  input  logic       remZero,
  input  logic       srWip,
  input  logic       pollAtLimit,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       spiCs,
  output logic       spiReq,
  output logic       donePulse,
  output logic [1:0] doneCode
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_NEXT,
    S_POLL_OP, S_POLL_RD, S_POLL_END,
    S_WREN_OP, S_WREN_END,
    S_ERS_OP, S_ERS_A2, S_ERS_A1, S_ERS_A0, S_ERS_END,
    S_DONE
  } state_e;

  state_e    st, stNext;
  doneCode_e codeQ, codeNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= S_IDLE;
      codeQ <= DONE_OK;
    end else begin
      st    <= stNext;
      codeQ <= codeNext;
    end
  end

  always_comb begin
    stNext       = st;
    codeNext     = codeQ;
    strobe       = '0;
    strobe.txSel = TX_STATUS;
    spiCs        = 1'b0;
    spiReq       = 1'b0;
    case (st)
      S_IDLE: begin
        if (startReq) begin
          strobe.load = 1'b1;
          stNext      = S_CHECK;
        end
      end
      S_CHECK: begin
        if (rangeBad) begin
          codeNext = DONE_RANGE;
          stNext   = S_DONE;
        end else begin
          stNext = S_NEXT;
        end
      end
      S_NEXT: begin
        if (remZero) begin
          codeNext = DONE_OK;
          stNext   = S_DONE;
        end else begin
          strobe.pollClr = 1'b1;
          stNext         = S_POLL_OP;
        end
      end
      S_POLL_OP: begin
        spiCs = 1'b1; spiReq = 1'b1; strobe.txSel = TX_STATUS;
        if (spiAck) stNext = S_POLL_RD;
      end
      S_POLL_RD: begin
        spiCs = 1'b1; spiReq = 1'b1; strobe.txSel = TX_DUMMY;
        if (spiAck) begin
          strobe.srLoad = 1'b1;
          stNext        = S_POLL_END;
        end
      end
      S_POLL_END: begin
        if (!srWip) begin
          stNext = S_WREN_OP;
        end else if (pollAtLimit) begin
          codeNext = DONE_TIMEOUT;
          stNext   = S_DONE;
        end else begin
          strobe.pollInc = 1'b1;
          stNext         = S_POLL_OP;
        end
      end
      S_WREN_OP: begin
        spiCs = 1'b1; spiReq = 1'b1; strobe.txSel = TX_WREN;
        if (spiAck) stNext = S_WREN_END;
      end
      S_WREN_END: stNext = S_ERS_OP;
      S_ERS_OP: begin
        spiCs = 1'b1; spiReq = 1'b1; strobe.txSel = TX_OPCODE;
        if (spiAck) stNext = S_ERS_A2;
      end
      S_ERS_A2: begin
        spiCs = 1'b1; spiReq = 1'b1; strobe.txSel = TX_ADDR_HI;
        if (spiAck) stNext = S_ERS_A1;
      end
      S_ERS_A1: begin
        spiCs = 1'b1; spiReq = 1'b1; strobe.txSel = TX_ADDR_MID;
        if (spiAck) stNext = S_ERS_A0;
      end
      S_ERS_A0: begin
        spiCs = 1'b1; spiReq = 1'b1; strobe.txSel = TX_ADDR_LO;
        if (spiAck) stNext = S_ERS_END;
      end
      S_ERS_END: begin
        strobe.advance = 1'b1;
        stNext         = S_NEXT;
      end
      S_DONE:  stNext = S_IDLE;
      default: stNext = S_IDLE;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign donePulse = (st == S_DONE);
  assign doneCode  = codeQ;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int DEV_LOG2   = 20,
  parameter int SMALL_LOG2 = 12,
  parameter int LARGE_LOG2 = 16,
  parameter int POLL_LIMIT = 100000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic [FES_ADDR_W-1:0] startAddr,
  input  logic [FES_LEN_W-1:0]  eraseLen,
  input  logic                  granSel,
  output logic                  busy,
  output logic                  donePulse,
  output logic [1:0]            doneCode,
  output logic                  spiCs,
  output logic                  spiReq,
  output logic [7:0]            spiTxData,
  input  logic                  spiAck,
  input  logic [7:0]            spiRxData
);

  ctlStrobe_t strobe;
  logic rangeBad, remZero, srWip, pollAtLimit;

  fes_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .spiAck      (spiAck),
    .rangeBad    (rangeBad),
    .remZero     (remZero),
    .srWip       (srWip),
    .pollAtLimit (pollAtLimit),
    .strobe      (strobe),
    .busy        (busy),
    .spiCs       (spiCs),
    .spiReq      (spiReq),
    .donePulse   (donePulse),
    .doneCode    (doneCode)
  );

  fes_dpath #(
    .DEV_LOG2   (DEV_LOG2),
    .SMALL_LOG2 (SMALL_LOG2),
    .LARGE_LOG2 (LARGE_LOG2),
    .POLL_LIMIT (POLL_LIMIT)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startAddr   (startAddr),
    .eraseLen    (eraseLen),
    .granSel     (granSel),
    .spiRxData   (spiRxData),
    .rangeBad    (rangeBad),
    .remZero     (remZero),
    .srWip       (srWip),
    .pollAtLimit (pollAtLimit),
    .txByte      (spiTxData)
  );

endmodule

// File: rtl/fes_chk.sv
module fes_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       busy,
  input logic       donePulse,
  input logic [1:0] doneCode,
  input logic       spiCs,
  input logic       spiReq,
  input logic [7:0] spiTxData,
  input logic       spiAck
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!spiCs && !spiReq && !donePulse));

  // R5
  frame_opcode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCs) |-> (spiReq && (spiTxData == 8'h05 || spiTxData == 8'h06 ||
                                 spiTxData == 8'h20 || spiTxData == 8'hD8)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R9
  done_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (doneCode != 2'd3));

  // R10
  req_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiReq |-> spiCs);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiReq && !spiAck) |=> (spiReq && $stable(spiTxData)));

  // R11
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

endmodule

bind flash_erase_seq fes_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .busy      (busy),
  .donePulse (donePulse),
  .doneCode  (doneCode),
  .spiCs     (spiCs),
  .spiReq    (spiReq),
  .spiTxData (spiTxData),
  .spiAck    (spiAck)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;

  localparam int POLL_LIM = 16;
  localparam int MAXF     = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startReq;
  logic [23:0] startAddr;
  logic [24:0] eraseLen;
  logic        granSel;
  logic        busy, donePulse, spiCs, spiReq;
  logic [1:0]  doneCode;
  logic [7:0]  spiTxData;
  logic        spiAck;
  logic [7:0]  spiRxData;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  // flash model state
  int frameCnt = 0;
  int busyLeft = 0;
  int busyAfter = 0;
  int ackDelay = 0;
  int dly = 0;
  int protoErr = 0;
  int doneCnt = 0;
  logic       csPrev = 1'b0;
  logic       reqPrev = 1'b0;
  logic       ackSeenPrev = 1'b0;
  logic [7:0] txPrev = 8'h00;
  logic [7:0] fb [MAXF][4];
  int         fl [MAXF];

  always #2.5 clk = ~clk;

  flash_erase_seq #(.POLL_LIMIT(POLL_LIM)) i_flash_erase_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .eraseLen(eraseLen), .granSel(granSel), .busy(busy),
    .donePulse(donePulse), .doneCode(doneCode), .spiCs(spiCs),
    .spiReq(spiReq), .spiTxData(spiTxData), .spiAck(spiAck),
    .spiRxData(spiRxData)
  );

  // Byte-handshake shifter plus flash status model
  always @(posedge clk) begin
    int fi, bi;
    logic [7:0] rx;
    if (!rstN) begin
      spiAck    <= 1'b0;
      spiRxData <= 8'h00;
      dly = 0;
      csPrev = 1'b0;
      reqPrev = 1'b0;
      ackSeenPrev = 1'b0;
    end else begin
      if (spiReq && !spiCs) protoErr++;
      if (reqPrev && !ackSeenPrev && (!spiReq || spiTxData != txPrev)) protoErr++;
      if (donePulse) doneCnt++;
      if (spiCs && !csPrev) begin
        if (frameCnt < MAXF) fl[frameCnt] = 0;
        frameCnt++;
      end
      if (spiAck) begin
        spiAck <= 1'b0;
      end else if (spiReq) begin
        if (dly >= ackDelay) begin
          dly = 0;
          rx = 8'hFF;
          fi = frameCnt - 1;
          if (fi >= 0 && fi < MAXF) begin
            bi = fl[fi];
            if (bi == 1 && fb[fi][0] == 8'h05) begin
              if (busyLeft > 0) begin
                rx = 8'h03;
                busyLeft--;
              end else begin
                rx = 8'h02;
              end
            end
            if (bi < 4) fb[fi][bi] = spiTxData;
            fl[fi] = bi + 1;
            if (bi == 3) busyLeft = busyAfter;
          end
          spiAck    <= 1'b1;
          spiRxData <= rx;
        end else begin
          dly++;
        end
      end
      csPrev = spiCs;
      reqPrev = spiReq;
      ackSeenPrev = spiAck;
      txPrev = spiTxData;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic runErase(input logic [23:0] a, input logic [24:0] len, input bit g,
                          input int bf, input int ba, input int dv, input bit inject,
                          input string req, input int expCode);
    int n;
    bit seen;
    @(negedge clk);
    frameCnt = 0; busyLeft = bf; busyAfter = ba; ackDelay = dv; doneCnt = 0;
    startAddr = a; eraseLen = len; granSel = g; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    n = 0;
    while (!donePulse && n < 20000) begin
      @(negedge clk);
      n++;
      if (inject && n == 10) begin
        startReq = 1'b1; startAddr = 24'h0F0000; eraseLen = 25'h1000; granSel = 1'b1;
      end else begin
        startReq = 1'b0;
      end
    end
    seen = donePulse;
    startReq = 1'b0;
    check(seen, "R9", "done pulse seen", seen, 1);
    check(doneCode == 2'(expCode), req, "done code", doneCode, expCode);
    @(negedge clk);
    check(!donePulse && doneCnt == 1, "R9", "single one-cycle done", doneCnt, 1);
  endtask

  task automatic checkFrames(input logic [23:0] a0, input bit g, input int nGran,
                             input int bf, input int ba, input bit toLast);
    int idx = 0;
    int statusBad = 0;
    int wrenBad = 0;
    int eraseBad = 0;
    int opcBad = 0;
    for (int k = 0; k < nGran; k++) begin
      int b;
      int np;
      logic [23:0] ea;
      b  = (k == 0) ? bf : ba;
      np = (toLast && k == nGran - 1) ? POLL_LIM : b + 1;
      for (int p = 0; p < np; p++) begin
        if (!(idx < frameCnt && idx < MAXF && fl[idx] == 2 && fb[idx][0] == 8'h05)) statusBad++;
        idx++;
      end
      if (toLast && k == nGran - 1) break;
      if (!(idx < frameCnt && idx < MAXF && fl[idx] == 1 && fb[idx][0] == 8'h06)) wrenBad++;
      idx++;
      ea = a0 + (g ? 24'(k * 65536) : 24'(k * 4096));
      if (!(idx < frameCnt && idx < MAXF && fl[idx] == 4 && fb[idx][1] == ea[23:16] &&
            fb[idx][2] == ea[15:8] && fb[idx][3] == ea[7:0])) eraseBad++;
      if (!(idx < frameCnt && idx < MAXF && fb[idx][0] == (g ? 8'hD8 : 8'h20))) opcBad++;
      idx++;
    end
    check(statusBad == 0, "R3", "status frames", statusBad, 0);
    check(wrenBad == 0, "R4", "write-enable frames", wrenBad, 0);
    check(eraseBad == 0, "R5", "erase address bytes", eraseBad, 0);
    check(opcBad == 0, "R6", "erase opcode", opcBad, 0);
    check(frameCnt == idx, "R7", "frame count", frameCnt, idx);
  endtask

  task automatic tReset();
    check(!busy && !donePulse, "R1", "busy/done after reset", {busy, donePulse}, 0);
    check(!spiCs && !spiReq, "R1", "bus idle after reset", {spiCs, spiReq}, 0);
  endtask

  task automatic tSmallSingle();
    runErase(24'h003000, 25'h1000, 1'b0, 2, 0, 0, 1'b0, "R9", 0);
    checkFrames(24'h003000, 1'b0, 1, 2, 0, 1'b0);
  endtask

  task automatic tLargeToEnd();
    // ends exactly at the device size: accepted
    runErase(24'h0E0000, 25'h20000, 1'b1, 0, 3, 2, 1'b0, "R7", 0);
    checkFrames(24'h0E0000, 1'b1, 2, 0, 3, 1'b0);
  endtask

  task automatic tReject();
    runErase(24'h001800, 25'h1000, 1'b0, 0, 0, 0, 1'b0, "R2", 1);
    check(frameCnt == 0, "R2", "no frames, misaligned start", frameCnt, 0);
    runErase(24'h010000, 25'h1000, 1'b1, 0, 0, 1, 1'b0, "R2", 1);
    check(frameCnt == 0, "R2", "no frames, misaligned length", frameCnt, 0);
    runErase(24'h0F0000, 25'h20000, 1'b1, 0, 0, 0, 1'b0, "R2", 1);
    check(frameCnt == 0, "R2", "no frames, past end", frameCnt, 0);
  endtask

  task automatic tTimeout();
    runErase(24'h005000, 25'h1000, 1'b0, POLL_LIM, 0, 1, 1'b0, "R8", 2);
    checkFrames(24'h005000, 1'b0, 1, POLL_LIM, 0, 1'b1);
    runErase(24'h006000, 25'h1000, 1'b0, POLL_LIM - 1, 0, 0, 1'b0, "R8", 0);
    checkFrames(24'h006000, 1'b0, 1, POLL_LIM - 1, 0, 1'b0);
  endtask

  task automatic tTimeoutSecond();
    runErase(24'h008000, 25'h3000, 1'b0, 0, POLL_LIM, 0, 1'b0, "R8", 2);
    checkFrames(24'h008000, 1'b0, 2, 0, POLL_LIM, 1'b1);
  endtask

  task automatic tZeroLen();
    runErase(24'h004000, 25'h0, 1'b0, 0, 0, 0, 1'b0, "R12", 0);
    check(frameCnt == 0, "R12", "no frames for zero length", frameCnt, 0);
  endtask

  task automatic tStartWhileBusy();
    runErase(24'h000000, 25'h3000, 1'b0, 4, 1, 1, 1'b1, "R11", 0);
    checkFrames(24'h000000, 1'b0, 3, 4, 1, 1'b0);
    check(!busy, "R11", "idle after run, injected start dropped", busy, 0);
  endtask

  initial begin
    rstN = 1'b0; startReq = 1'b0; startAddr = '0; eraseLen = '0; granSel = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSmallSingle();
    tLargeToEnd();
    tReject();
    tTimeout();
    tTimeoutSecond();
    tZeroLen();
    tStartWhileBusy();
    check(protoErr == 0, "R10", "request held in frame until ack", protoErr, 0);
    summary();
    $finish;
  end

endmodule